// File: doc/BRIEF.md
# Management Command Mailbox with Background Operations

This block is the command interface that a management agent uses to drive a managed memory or switch component. The agent writes a 16-bit opcode into the command register. The upper byte of the opcode selects a command set and the lower byte selects a command within that set. The block has no command queue. It accepts a command only when nothing else is outstanding.

Each opcode falls into one of three classes:

- **Foreground opcodes** run for a fixed number of cycles. They then post a success code.
- **Background opcodes** get an immediate "started" reply. The component then emits a percent-complete report every `TICK_CYCLES` clocks, which is two seconds at the default rate. A final completion report follows when the work ends.
- **Unknown opcodes** get an "unsupported" code at once.

A stub worker stands in for the real work. Its length in cycles is programmable. Completion can raise a sticky interrupt when the agent has enabled it. Every status field can be read at any time.

The controller has three states:

- **IDLE**
- **FG_EXEC**, a foreground command running
- **BG_RUN**, a background operation running

It has six transitions:

- **IDLE→FG_EXEC**: a foreground opcode is accepted.
- **IDLE→BG_RUN**: a background opcode is accepted.
- **IDLE→IDLE**: an unsupported opcode is reported.
- **FG_EXEC→IDLE**: the foreground latency has elapsed.
- **BG_RUN→IDLE**: the worker has finished.
- **FG_EXEC/BG_RUN self-loop**: a command written in either state is rejected as busy.

Registers are 32-bit words at these word addresses:

| Address | Name | Access | Contents |
|---|---|---|---|
| 0 | command | write launches, read returns the last accepted opcode | opcode |
| 1 | control | read/write | bit 0: interrupt enable |
| 2 | work length | read/write | background work length in cycles |
| 3 | response | read | return code in bits 2:0 |
| 4 | background status | read; bit 16 is write-1-to-clear | bit 0: running; bit 1: done; bits 14:8: percent complete; bit 16: interrupt pending |

Return codes are:

| Code | Meaning |
|---|---|
| 0 | success |
| 1 | background started |
| 2 | busy |
| 3 | unsupported |
| 4 | pending |

The event port emits one-cycle events. The `evt_kind` encoding is:

| `evt_kind` | Event |
|---|---|
| 1 | started |
| 2 | progress |
| 3 | done |

Top module: `mgmt_mailbox`

## Requirements
- R1: Opcodes with set byte 0x01 and command byte 0x00–0x03 are foreground, and opcodes with set byte 0x02 and command byte 0x00–0x01 are background. Any other opcode written while idle sets the response code to 3 (unsupported) one cycle later and starts nothing.
- R2: A foreground opcode sets the response code to 4 (pending) one cycle after the write. The code becomes 0 (success) FG_LAT cycles after the write.
- R3: A background opcode sets the response code to 1 (started) one cycle after the write. In the same cycle it emits a started event (evt_kind 1) with percent 0.
- R4: A command written while a command is outstanding sets the response code to 2 (busy). The running operation keeps its opcode and its completion cycle.
- R5: While a background operation of length L runs, a progress event (evt_kind 2) occurs after every TICK_CYCLES cycles of run time, except at the cycle where the work ends. This gives floor((L−1)/TICK_CYCLES) events. The n-th event carries percent floor(n·TICK_CYCLES·100/L).
- R6: The 7-bit percent field never exceeds 100. It reads 0 right after a new background operation is accepted.
- R7: After L cycles of work the block emits a done event (evt_kind 3) with percent 100. In background status it sets done=1, running=0 and percent=100.
- R8: With interrupt enable set, completion sets a sticky pending bit that drives `irq`. Writing 1 to bit 16 of background status clears the bit, and writing 0 leaves it set. With interrupt enable clear, `irq` stays low.
- R9: After reset all readable registers hold 0, `irq` is low and no event is emitted.
- R10: A work length of 0 is treated as 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write word address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read word address |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| irq | output | 1 | Completion interrupt (sticky pending bit) |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_kind | output | 2 | Event kind: 1 started, 2 progress, 3 done |
| evt_pct | output | 7 | Percent complete carried by the event |

## Verification
Suppose the controller state is wrong, for example a run that does not leave BG_RUN. This shows up within one cycle of the expected end: the done event is missing, and the running bit stays high when it is read. A worker or timer that is off by one changes the number of progress events, or the cycle distance between the started event and the done event. The bench compares both against figures derived from L and TICK_CYCLES. A bad percent calculation shows up on the first progress event. A lost busy rejection shows up in the response code read one cycle after the write.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FG_EXEC = 2'd1,
        ST_BG_RUN  = 2'd2
    } mbx_state_e;

    typedef enum logic [2:0] {
        RC_SUCCESS     = 3'd0,
        RC_BG_STARTED  = 3'd1,
        RC_BUSY        = 3'd2,
        RC_UNSUPPORTED = 3'd3,
        RC_PENDING     = 3'd4
    } mbx_rc_e;

    typedef enum logic [1:0] {
        EV_NONE     = 2'd0,
        EV_STARTED  = 2'd1,
        EV_PROGRESS = 2'd2,
        EV_DONE     = 2'd3
    } mbx_evt_e;

    typedef enum logic [1:0] {
        OPC_UNSUP = 2'd0,
        OPC_FG    = 2'd1,
        OPC_BG    = 2'd2
    } opc_class_e;

    // Register word addresses
    localparam int unsigned REG_CMD  = 0;
    localparam int unsigned REG_CTRL = 1;
    localparam int unsigned REG_WLEN = 2;
    localparam int unsigned REG_RESP = 3;
    localparam int unsigned REG_BGST = 4;

    // Background status bit positions
    localparam int unsigned BGST_RUN_BIT  = 0;
    localparam int unsigned BGST_DONE_BIT = 1;
    localparam int unsigned BGST_PCT_LSB  = 8;
    localparam int unsigned BGST_IRQ_BIT  = 16;

    localparam logic [6:0] PCT_FULL = 7'd100;

    // Command set / command classification table
    function automatic opc_class_e classify_op(input logic [15:0] op);
        logic [7:0] cset;
        logic [7:0] cmd;
        cset = op[15:8];
        cmd  = op[7:0];
        if (cset == 8'h01 && cmd <= 8'h03)      return OPC_FG;
        else if (cset == 8'h02 && cmd <= 8'h01) return OPC_BG;
        else                                     return OPC_UNSUP;
    endfunction

endpackage

// File: rtl/mbx_worker.sv
module mbx_worker #(
    parameter int WORK_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORK_W-1:0] start_len,
    output logic              active,
    output logic              last,
    output logic [WORK_W-1:0] cnt,
    output logic [WORK_W-1:0] len
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            len    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
            len    <= start_len;
        end else if (active) begin
            if (last) begin
                active <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        last = active && (cnt == len - 1'b1);
    end

endmodule

// File: rtl/mbx_ticker.sv
module mbx_ticker #(
    parameter int TICK_CYCLES = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic tick
);

    localparam int TW = $clog2(TICK_CYCLES + 1);
    localparam logic [TW-1:0] TMAX = TW'(TICK_CYCLES - 1);

    logic [TW-1:0] tcnt;

    always_comb begin
        tick = en && (tcnt == TMAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt <= '0;
        end else if (clr) begin
            tcnt <= '0;
        end else if (en) begin
            tcnt <= tick ? '0 : tcnt + 1'b1;
        end
    end

endmodule

// File: rtl/mbx_percent.sv
module mbx_percent #(
    parameter int WORK_W = 24
) (
    input  logic [WORK_W-1:0] done_cnt,
    input  logic [WORK_W-1:0] total,
    output logic [6:0]        pct
);

    localparam int NW = WORK_W + 8;

    logic [NW-1:0] num;
    logic [NW-1:0] den;
    logic [NW-1:0] quo;

    always_comb begin
        num = (NW'(done_cnt) + NW'(1)) * NW'(100);
        den = (total == '0) ? NW'(1) : NW'(total);
        quo = num / den;
        pct = (quo > NW'(100)) ? 7'd100 : quo[6:0];
    end

endmodule

// File: rtl/mbx_fsm.sv
module mbx_fsm
    import mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [15:0] opcode,
    input  logic       work_last,
    input  logic       tick,
    output mbx_state_e state,
    output logic       fg_accept,
    output logic       bg_accept,
    output logic       unsup,
    output logic       busy_rej,
    output logic       fg_finish,
    output logic       bg_finish,
    output logic       prog
);

    mbx_state_e state_d;
    opc_class_e op_class;

    always_comb begin
        op_class = classify_op(opcode);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_wr && op_class == OPC_FG)      state_d = ST_FG_EXEC;
                else if (cmd_wr && op_class == OPC_BG) state_d = ST_BG_RUN;
            end
            ST_FG_EXEC: begin
                if (work_last) state_d = ST_IDLE;
            end
            ST_BG_RUN: begin
                if (work_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output strobes
    always_comb begin
        fg_accept = 1'b0;
        bg_accept = 1'b0;
        unsup     = 1'b0;
        busy_rej  = 1'b0;
        fg_finish = 1'b0;
        bg_finish = 1'b0;
        prog      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_wr) begin
                    unique case (op_class)
                        OPC_FG:  fg_accept = 1'b1;
                        OPC_BG:  bg_accept = 1'b1;
                        default: unsup     = 1'b1;
                    endcase
                end
            end
            ST_FG_EXEC: begin
                busy_rej  = cmd_wr;
                fg_finish = work_last;
            end
            ST_BG_RUN: begin
                busy_rej  = cmd_wr;
                bg_finish = work_last;
                prog      = tick && !work_last;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mgmt_mailbox.sv
module mgmt_mailbox
    import mbx_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 32,
    parameter int WORK_W      = 24,
    parameter int TICK_CYCLES = 100_000_000,
    parameter int FG_LAT      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              evt_valid,
    output logic [1:0]        evt_kind,
    output logic [6:0]        evt_pct
);

    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(REG_CMD);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] A_WLEN = ADDR_W'(REG_WLEN);
    localparam logic [ADDR_W-1:0] A_RESP = ADDR_W'(REG_RESP);
    localparam logic [ADDR_W-1:0] A_BGST = ADDR_W'(REG_BGST);
    localparam logic [WORK_W-1:0] FG_LEN = WORK_W'(FG_LAT);

    logic              cmd_wr;
    logic [15:0]       opcode_in;
    mbx_state_e        fsm_state;
    logic              fg_accept, bg_accept, unsup, busy_rej;
    logic              fg_finish, bg_finish, prog;
    logic              work_active, work_last;
    logic [WORK_W-1:0] work_cnt, work_len;
    logic [WORK_W-1:0] start_len;
    logic              tick;
    logic [6:0]        pct_now;

    logic [15:0]       last_op_q;
    logic              irq_en_q;
    logic [WORK_W-1:0] wlen_q;
    mbx_rc_e           resp_q;
    logic              bg_done_q;
    logic [6:0]        pct_q;
    logic              irq_pend_q;
    logic              irq_clr;

    always_comb begin
        cmd_wr    = wr_en && (wr_addr == A_CMD);
        opcode_in = wr_data[15:0];
        irq_clr   = wr_en && (wr_addr == A_BGST) && wr_data[BGST_IRQ_BIT];
        if (fg_accept)           start_len = FG_LEN;
        else if (wlen_q == '0)   start_len = WORK_W'(1);
        else                     start_len = wlen_q;
    end

    mbx_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .opcode    (opcode_in),
        .work_last (work_last),
        .tick      (tick),
        .state     (fsm_state),
        .fg_accept (fg_accept),
        .bg_accept (bg_accept),
        .unsup     (unsup),
        .busy_rej  (busy_rej),
        .fg_finish (fg_finish),
        .bg_finish (bg_finish),
        .prog      (prog)
    );

    mbx_worker #(.WORK_W(WORK_W)) u_worker (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (fg_accept | bg_accept),
        .start_len (start_len),
        .active    (work_active),
        .last      (work_last),
        .cnt       (work_cnt),
        .len       (work_len)
    );

    mbx_ticker #(.TICK_CYCLES(TICK_CYCLES)) u_ticker (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (bg_accept),
        .en    (fsm_state == ST_BG_RUN),
        .tick  (tick)
    );

    mbx_percent #(.WORK_W(WORK_W)) u_pct (
        .done_cnt (work_cnt),
        .total    (work_len),
        .pct      (pct_now)
    );

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en_q <= 1'b0;
            wlen_q   <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL) irq_en_q <= wr_data[0];
            if (wr_addr == A_WLEN) wlen_q   <= wr_data[WORK_W-1:0];
        end
    end

    // Response code and last accepted opcode; the newest command wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q    <= RC_SUCCESS;
            last_op_q <= '0;
        end else begin
            if (fg_accept | bg_accept) last_op_q <= opcode_in;
            if (busy_rej)       resp_q <= RC_BUSY;
            else if (unsup)     resp_q <= RC_UNSUPPORTED;
            else if (fg_accept) resp_q <= RC_PENDING;
            else if (bg_accept) resp_q <= RC_BG_STARTED;
            else if (fg_finish) resp_q <= RC_SUCCESS;
        end
    end

    // Background status and sticky interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bg_done_q  <= 1'b0;
            pct_q      <= '0;
            irq_pend_q <= 1'b0;
        end else begin
            if (bg_accept) begin
                bg_done_q <= 1'b0;
                pct_q     <= '0;
            end else if (bg_finish) begin
                bg_done_q <= 1'b1;
                pct_q     <= PCT_FULL;
            end else if (prog) begin
                pct_q     <= pct_now;
            end
            if (bg_finish && irq_en_q) irq_pend_q <= 1'b1;
            else if (irq_clr)          irq_pend_q <= 1'b0;
        end
    end

    // Event port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_kind  <= EV_NONE;
            evt_pct   <= '0;
        end else begin
            evt_valid <= bg_accept | prog | bg_finish;
            if (bg_accept) begin
                evt_kind <= EV_STARTED;
                evt_pct  <= '0;
            end else if (bg_finish) begin
                evt_kind <= EV_DONE;
                evt_pct  <= PCT_FULL;
            end else if (prog) begin
                evt_kind <= EV_PROGRESS;
                evt_pct  <= pct_now;
            end else begin
                evt_kind <= EV_NONE;
                evt_pct  <= '0;
            end
        end
    end

    always_comb begin
        irq = irq_pend_q;
    end

    // Register read mux
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CMD:  rd_data[15:0]       = last_op_q;
            A_CTRL: rd_data[0]          = irq_en_q;
            A_WLEN: rd_data[WORK_W-1:0] = wlen_q;
            A_RESP: rd_data[2:0]        = resp_q;
            A_BGST: begin
                rd_data[BGST_RUN_BIT]                 = (fsm_state == ST_BG_RUN);
                rd_data[BGST_DONE_BIT]                = bg_done_q;
                rd_data[BGST_PCT_LSB+6:BGST_PCT_LSB]  = pct_q;
                rd_data[BGST_IRQ_BIT]                 = irq_pend_q;
            end
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              irq,
    input logic              evt_valid,
    input logic [1:0]        evt_kind,
    input logic [6:0]        evt_pct,
    input logic              irq_en,
    input logic [2:0]        resp,
    input logic [1:0]        state
);

    logic cmd_w;
    logic clr_w;
    assign cmd_w = wr_en && (wr_addr == ADDR_W'(REG_CMD));
    assign clr_w = wr_en && (wr_addr == ADDR_W'(REG_BGST)) && wr_data[BGST_IRQ_BIT];

    AST_PCT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> evt_pct <= 7'd100); // R6

    AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == EV_DONE) |-> evt_pct == 7'd100); // R7

    AST_START_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == EV_STARTED) |-> (evt_pct == 7'd0 && $past(cmd_w))); // R3

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(irq_en) && evt_valid && evt_kind == EV_DONE)); // R8

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_w) |=> irq); // R8

    AST_BUSY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && state != ST_IDLE) |=> resp == RC_BUSY); // R4

    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && state == ST_BG_RUN) |=> !(evt_valid && evt_kind == EV_STARTED)); // R4

    AST_PROG_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == EV_PROGRESS) |-> $past(state) == ST_BG_RUN); // R5

endmodule

bind mgmt_mailbox mbx_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .irq       (irq),
    .evt_valid (evt_valid),
    .evt_kind  (evt_kind),
    .evt_pct   (evt_pct),
    .irq_en    (irq_en_q),
    .resp      (resp_q),
    .state     (fsm_state)
);

// File: tb/mgmt_mailbox_test.sv
module mgmt_mailbox_test;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;
    localparam int WORK_W = 24;
    localparam int TICK   = 8;
    localparam int FGL    = 4;

    typedef struct packed {
        logic [15:0] op;
        logic [15:0] len;
        logic        irq_en;
        logic [2:0]  rc_now;
        logic [2:0]  rc_fin;
        logic [3:0]  nprog;
        logic        is_bg;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{16'h0101, 16'd0,  1'b1, 3'd4, 3'd0, 4'd0, 1'b0, 1'b0},
        '{16'h0201, 16'd20, 1'b1, 3'd1, 3'd1, 4'd2, 1'b1, 1'b1},
        '{16'h0200, 16'd8,  1'b0, 3'd1, 3'd1, 4'd0, 1'b1, 1'b0},
        '{16'h0200, 16'd33, 1'b1, 3'd1, 3'd1, 4'd4, 1'b1, 1'b1},
        '{16'h0305, 16'd0,  1'b0, 3'd3, 3'd3, 4'd0, 1'b0, 1'b0},
        '{16'h01FF, 16'd0,  1'b0, 3'd3, 3'd3, 4'd0, 1'b0, 1'b0},
        '{16'h0104, 16'd0,  1'b0, 3'd3, 3'd3, 4'd0, 1'b0, 1'b0},
        '{16'h0103, 16'd0,  1'b0, 3'd4, 3'd0, 4'd0, 1'b0, 1'b0},
        '{16'h0202, 16'd0,  1'b0, 3'd3, 3'd3, 4'd0, 1'b0, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic              irq;
    logic              evt_valid;
    logic [1:0]        evt_kind;
    logic [6:0]        evt_pct;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_start = 0, n_prog = 0, n_done = 0, pct_bad = 0;
    int start_cyc = 0, done_cyc = 0;
    int cur_len = 1;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    mgmt_mailbox #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORK_W(WORK_W),
        .TICK_CYCLES(TICK), .FG_LAT(FGL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq(irq), .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_pct(evt_pct)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Event monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && evt_valid) begin
            case (evt_kind)
                2'd1: begin n_start++; start_cyc = cyc; if (evt_pct != 0) pct_bad++; end
                2'd2: begin
                    n_prog++;
                    if (int'(evt_pct) != (n_prog * TICK * 100) / cur_len) pct_bad++;
                end
                2'd3: begin n_done++; done_cyc = cyc; if (evt_pct != 100) pct_bad++; end
                default: pct_bad++;
            endcase
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [DATA_W-1:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = ADDR_W'(addr);
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [DATA_W-1:0] data);
        rd_addr = ADDR_W'(addr);
        #1;
        data = rd_data;
    endtask

    task automatic clear_counts();
        n_start = 0; n_prog = 0; n_done = 0; pct_bad = 0;
    endtask

    task automatic wait_idle();
        logic [DATA_W-1:0] st, rs;
        for (int k = 0; k < 2000; k++) begin
            rd(4, st);
            rd(3, rs);
            if (!st[0] && rs[2:0] != 3'd4) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] d;
        repeat (3) @(negedge clk);

        // R9: reset state
        for (int a = 0; a < 5; a++) begin
            rd(a, d);
            check(d == 0, "R9 reg reset", int'(d), 0);
        end
        check(irq == 0 && evt_valid == 0, "R9 irq/evt reset", int'(irq), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            cur_len = (v.len == 0) ? 1 : int'(v.len);
            wr(2, DATA_W'(v.len));
            wr(1, DATA_W'(v.irq_en));
            clear_counts();
            wr(0, DATA_W'(v.op));
            rd(3, d);
            check(d[2:0] == v.rc_now, v.is_bg ? "R3 started code" :
                  (v.rc_now == 3'd3 ? "R1 unsupported code" : "R2 pending code"),
                  int'(d[2:0]), int'(v.rc_now));
            if (v.is_bg) begin
                rd(4, d);
                check(d[14:8] == 0 && d[0], "R6 pct zero on accept", int'(d[14:8]), 0);
            end
            wait_idle();
            rd(3, d);
            check(d[2:0] == v.rc_fin, v.rc_fin == 3'd0 ? "R2 success code" : "R1 final code",
                  int'(d[2:0]), int'(v.rc_fin));
            check(n_prog == int'(v.nprog), "R5 progress count", n_prog, int'(v.nprog));
            check(n_start == int'(v.is_bg) && n_done == int'(v.is_bg), "R7 done count",
                  n_done, int'(v.is_bg));
            check(pct_bad == 0, "R5 progress percent", pct_bad, 0);
            if (v.is_bg) begin
                rd(4, d);
                check(d[1] && !d[0] && d[14:8] == 7'd100, "R7 done status",
                      int'(d[14:8]), 100);
                check(done_cyc - start_cyc == cur_len, "R7 completion time",
                      done_cyc - start_cyc, cur_len);
            end
            check(irq == v.exp_irq, "R8 irq level", int'(irq), int'(v.exp_irq));
            if (irq) begin
                wr(4, 32'h0);
                check(irq == 1'b1, "R8 write 0 keeps irq", int'(irq), 1);
                wr(4, 32'h1 << 16);
                check(irq == 1'b0, "R8 write 1 clears irq", int'(irq), 0);
            end
        end

        // R4: busy rejection during a background run
        cur_len = 40;
        wr(2, 40);
        wr(1, 1);
        clear_counts();
        wr(0, 32'h0201);
        repeat (5) @(negedge clk);
        wr(0, 32'h0101);
        rd(3, d);
        check(d[2:0] == 3'd2, "R4 busy code", int'(d[2:0]), 2);
        rd(4, d);
        check(d[0] == 1'b1, "R4 run continues", int'(d[0]), 1);
        rd(0, d);
        check(d[15:0] == 16'h0201, "R4 opcode kept", int'(d[15:0]), 'h0201);
        wait_idle();
        check(done_cyc - start_cyc == 40, "R4 completion unaffected", done_cyc - start_cyc, 40);
        check(n_start == 1, "R4 no restart", n_start, 1);
        check(n_prog == 4 && pct_bad == 0, "R5 progress on long run", n_prog, 4);
        wr(4, 32'h1 << 16);

        // R4: busy during foreground execution
        wr(0, 32'h0100);
        wr(0, 32'h0200);
        rd(3, d);
        check(d[2:0] == 3'd2, "R4 busy during foreground", int'(d[2:0]), 2);
        wait_idle();
        repeat (FGL) @(negedge clk);

        // R10: zero work length
        cur_len = 1;
        wr(2, 0);
        wr(1, 0);
        clear_counts();
        wr(0, 32'h0200);
        wait_idle();
        check(n_done == 1 && done_cyc - start_cyc == 1, "R10 zero length", done_cyc - start_cyc, 1);
        check(n_prog == 0, "R10 no progress", n_prog, 0);
        check(irq == 1'b0, "R8 disabled irq", int'(irq), 0);

        // R6: percent cleared by new accept after a finished run
        wr(2, 10);
        wr(0, 32'h0201);
        rd(4, d);
        check(d[14:8] == 0, "R6 pct cleared", int'(d[14:8]), 0);
        wait_idle();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
        $finish;
    end

endmodule